// File: doc/BRIEF.md
# Split-Transaction Timeout and Retry Controller

This block supervises one outstanding asynchronous request on a serial-bus link. When a packet is sent, it waits for the link acknowledge. A complete acknowledge closes the transaction at once. A busy acknowledge asks for a single-phase resend, up to a programmable limit. When the limit is used up, the block gives up on the packet. A pending acknowledge starts a split-transaction timer. The timer is clocked by an 8000 Hz tick input, one tick per 125 µs bus cycle. If no response arrives before the programmed time has elapsed, the timer flags a timeout.

The time limit has two parts: whole seconds, plus a count of 1/8000-second fractions. A control word holds this limit, the retry limit and a transmitter-off bit. The transmitter-off bit is clear at power-up. Every bus reset sets it, which switches the transmitter off until software writes the bit back to zero. A bus reset also abandons any transaction in flight. The packet datapath and arbitration are outside this block: `retry_req`, `timeout` and `give_up` are one-cycle pulses for the surrounding logic.

Top module: `split_txn_timer`

## Requirements
- R1: After `rst_n` is released, the control word has fractions = 800, seconds = 0, retry limit = 3 and transmitter-off = 0. `tx_enable` is 1 and all three event pulses are 0.
- R2: A cycle with `ctl_wr` high loads `ctl_wdata` into the control word, effective from the next cycle. The fields are: bits [12:0] fractions (1/8000 s units), bits [15:13] whole seconds, bits [19:16] retry limit and bit [20] transmitter-off. `tx_enable` is the inverse of bit [20].
- R3: A cycle with `bus_reset` high sets transmitter-off, so `tx_enable` is 0 in the next cycle. This wins over a `ctl_wr` in the same cycle. The same cycle abandons any transaction, clears the timer and the retry count, and suppresses all pulses in the next cycle. Writing bit [20] = 0 afterwards enables the transmitter again.
- R4: `tx_start` opens a transaction, with the retry count cleared, only when no transaction is open and `tx_enable` is 1. Otherwise it is ignored.
- R5: An acknowledge with code 0 (complete) closes the open transaction without a pulse and without starting the timer.
- R6: An acknowledge with code 2 (busy), received while the retry count is below the limit, raises `retry_req` for one cycle, in the cycle after the acknowledge. It increments the count and keeps waiting for an acknowledge.
- R7: An acknowledge with code 2 (busy), received when the retry count equals the limit, raises `give_up` for one cycle, in the cycle after the acknowledge, and closes the transaction. With a limit of 0 the first busy gives up.
- R8: An acknowledge with code 1 (pending) starts the timer from zero elapsed ticks. Each later `tick` adds one tick, with the fraction count wrapping from 7999 to 0 into the seconds count. Let E be the number of elapsed ticks. `timeout` pulses in the cycle after the tick where E/8000 > seconds, or where E/8000 = seconds and E mod 8000 >= fractions. The same tick closes the transaction.
- R9: `rsp_rcvd` during the timed wait closes the transaction with no `timeout`. This holds even when it comes in the same cycle as the tick that would expire the timer.
- R10: Acknowledge code 3 is ignored. Any acknowledge that arrives when the block is not waiting for an acknowledge is ignored.
- R11: `tx_start` while a transaction is open has no effect on the transaction in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| tick | input | 1 | 8000 Hz timing strobe, one cycle wide |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 21 | Control word value |
| tx_start | input | 1 | A new request packet has been sent |
| ack_valid | input | 1 | An acknowledge code is present |
| ack_code | input | 2 | 0 complete, 1 pending, 2 busy, 3 ignored |
| rsp_rcvd | input | 1 | The matching response has arrived |
| bus_reset | input | 1 | Bus reset seen on the link |
| retry_req | output | 1 | Pulse: resend the busy-acknowledged packet |
| timeout | output | 1 | Pulse: the split transaction has expired |
| give_up | output | 1 | Pulse: the retry limit is used up and the packet is dropped |
| tx_enable | output | 1 | The transmitter may operate |

## Verification
Two collisions matter most. The first is a response arriving in the very cycle of the tick that would expire the timer. The bench drives `rsp_rcvd` and the expiring `tick` together and expects no `timeout`, because the response takes precedence. The second is a bus reset coinciding with a software write that clears the transmitter-off bit. The bench issues both in one cycle and expects `tx_enable` to stay low until a later, separate write. A behavioural model compares all four outputs against the design on every clock.

// File: rtl/stt_pkg.sv
package stt_pkg;
   typedef enum logic [1:0] {
      ACK_COMPLETE = 2'd0,
      ACK_PENDING  = 2'd1,
      ACK_BUSY     = 2'd2,
      ACK_RSVD     = 2'd3
   } ack_e;

   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_ACK_WAIT = 2'd1,
      ST_RSP_WAIT = 2'd2
   } txn_state_e;
endpackage

// File: rtl/stt_ctl_reg.sv
module stt_ctl_reg #(
   parameter int FRAC_W    = 13,
   parameter int SEC_W     = 3,
   parameter int RETRY_W   = 4,
   parameter int FRAC_RST  = 800,
   parameter int RETRY_RST = 3,
   localparam int CTL_W    = FRAC_W + SEC_W + RETRY_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [CTL_W-1:0]   wdata,
   input  logic               bus_reset,
   output logic               txoff,
   output logic [RETRY_W-1:0] max_retry,
   output logic [SEC_W-1:0]   tmo_sec,
   output logic [FRAC_W-1:0]  tmo_frac
);
   localparam int SEC_LSB   = FRAC_W;
   localparam int RETRY_LSB = FRAC_W + SEC_W;
   localparam int OFF_BIT   = FRAC_W + SEC_W + RETRY_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmo_frac  <= FRAC_W'(FRAC_RST);
         tmo_sec   <= '0;
         max_retry <= RETRY_W'(RETRY_RST);
         txoff     <= 1'b0;
      end else begin
         if (wr) begin
            tmo_frac  <= wdata[FRAC_W-1:0];
            tmo_sec   <= wdata[SEC_LSB +: SEC_W];
            max_retry <= wdata[RETRY_LSB +: RETRY_W];
         end
         if (bus_reset)
            txoff <= 1'b1;
         else if (wr)
            txoff <= wdata[OFF_BIT];
      end
   end
endmodule

// File: rtl/stt_tick_timer.sv
module stt_tick_timer #(
   parameter int FRAC_W        = 13,
   parameter int SEC_W         = 3,
   parameter int TICKS_PER_SEC = 8000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              adv,
   input  logic [SEC_W-1:0]  cfg_sec,
   input  logic [FRAC_W-1:0] cfg_frac,
   output logic              expire
);
   localparam int CSEC_W = SEC_W + 1;

   logic [FRAC_W-1:0] frac_q, frac_n;
   logic [CSEC_W-1:0] sec_q, sec_n;
   logic              wrap;

   generate
      if (TICKS_PER_SEC == (1 << FRAC_W)) begin : g_pow2
         assign wrap = &frac_q;
      end else begin : g_cmp
         localparam logic [FRAC_W-1:0] FRAC_LAST = FRAC_W'(TICKS_PER_SEC - 1);
         assign wrap = (frac_q == FRAC_LAST);
      end
   endgenerate

   always_comb begin
      frac_n = wrap ? '0 : frac_q + 1'b1;
      sec_n  = sec_q;
      if (wrap && !(&sec_q))
         sec_n = sec_q + 1'b1;
   end

   assign expire = (sec_n > {1'b0, cfg_sec}) ||
                   ((sec_n == {1'b0, cfg_sec}) && (frac_n >= cfg_frac));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frac_q <= '0;
         sec_q  <= '0;
      end else if (clr) begin
         frac_q <= '0;
         sec_q  <= '0;
      end else if (adv) begin
         frac_q <= frac_n;
         sec_q  <= sec_n;
      end
   end
endmodule

// File: rtl/stt_retry_ctr.sv
module stt_retry_ctr #(
   parameter int RETRY_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               inc,
   input  logic [RETRY_W-1:0] limit,
   output logic               room
);
   logic [RETRY_W-1:0] cnt_q;

   assign room = (cnt_q < limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (inc && room)
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/split_txn_timer.sv
module split_txn_timer #(
   parameter int FRAC_W        = 13,
   parameter int SEC_W         = 3,
   parameter int RETRY_W       = 4,
   parameter int TICKS_PER_SEC = 8000,
   parameter int FRAC_RST      = 800,
   parameter int RETRY_RST     = 3,
   localparam int CTL_W        = FRAC_W + SEC_W + RETRY_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ctl_wr,
   input  logic [CTL_W-1:0] ctl_wdata,
   input  logic             tx_start,
   input  logic             ack_valid,
   input  logic [1:0]       ack_code,
   input  logic             rsp_rcvd,
   input  logic             bus_reset,
   output logic             retry_req,
   output logic             timeout,
   output logic             give_up,
   output logic             tx_enable
);
   import stt_pkg::*;

   generate
      if (TICKS_PER_SEC < 2 || TICKS_PER_SEC > (1 << FRAC_W)) begin : g_bad_tps
         $error("TICKS_PER_SEC must fit the fraction field");
      end
      if (FRAC_RST >= (1 << FRAC_W) || RETRY_RST >= (1 << RETRY_W)) begin : g_bad_rst
         $error("reset values must fit their fields");
      end
   endgenerate

   logic               txoff;
   logic [RETRY_W-1:0] max_retry;
   logic [SEC_W-1:0]   tmo_sec;
   logic [FRAC_W-1:0]  tmo_frac;

   stt_ctl_reg #(
      .FRAC_W(FRAC_W), .SEC_W(SEC_W), .RETRY_W(RETRY_W),
      .FRAC_RST(FRAC_RST), .RETRY_RST(RETRY_RST)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
      .bus_reset(bus_reset), .txoff(txoff), .max_retry(max_retry),
      .tmo_sec(tmo_sec), .tmo_frac(tmo_frac)
   );

   txn_state_e state_q, state_d;
   logic       tmr_clr, tmr_adv, tmr_expire;
   logic       rc_clr, rc_inc, rc_room;
   logic       retry_d, tmo_d, give_d;
   ack_e       ack;

   assign ack = ack_e'(ack_code);

   stt_tick_timer #(
      .FRAC_W(FRAC_W), .SEC_W(SEC_W), .TICKS_PER_SEC(TICKS_PER_SEC)
   ) u_tmr (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .adv(tmr_adv),
      .cfg_sec(tmo_sec), .cfg_frac(tmo_frac), .expire(tmr_expire)
   );

   stt_retry_ctr #(.RETRY_W(RETRY_W)) u_rc (
      .clk(clk), .rst_n(rst_n), .clr(rc_clr), .inc(rc_inc),
      .limit(max_retry), .room(rc_room)
   );

   always_comb begin
      state_d = state_q;
      tmr_clr = 1'b0;
      tmr_adv = 1'b0;
      rc_clr  = 1'b0;
      rc_inc  = 1'b0;
      retry_d = 1'b0;
      tmo_d   = 1'b0;
      give_d  = 1'b0;
      if (bus_reset) begin
         state_d = ST_IDLE;
         tmr_clr = 1'b1;
         rc_clr  = 1'b1;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (tx_start && !txoff) begin
                  state_d = ST_ACK_WAIT;
                  rc_clr  = 1'b1;
               end
            end
            ST_ACK_WAIT: begin
               if (ack_valid) begin
                  unique case (ack)
                     ACK_COMPLETE: state_d = ST_IDLE;
                     ACK_PENDING: begin
                        state_d = ST_RSP_WAIT;
                        tmr_clr = 1'b1;
                     end
                     ACK_BUSY: begin
                        if (rc_room) begin
                           rc_inc  = 1'b1;
                           retry_d = 1'b1;
                        end else begin
                           give_d  = 1'b1;
                           state_d = ST_IDLE;
                        end
                     end
                     default: ;
                  endcase
               end
            end
            ST_RSP_WAIT: begin
               if (rsp_rcvd) begin
                  state_d = ST_IDLE;
               end else if (tick) begin
                  if (tmr_expire) begin
                     tmo_d   = 1'b1;
                     state_d = ST_IDLE;
                  end else begin
                     tmr_adv = 1'b1;
                  end
               end
            end
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         retry_req <= 1'b0;
         timeout   <= 1'b0;
         give_up   <= 1'b0;
      end else begin
         state_q   <= state_d;
         retry_req <= retry_d;
         timeout   <= tmo_d;
         give_up   <= give_d;
      end
   end

   assign tx_enable = ~txoff;
endmodule

// File: rtl/stt_checker.sv
module stt_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       tick,
   input logic       ack_valid,
   input logic [1:0] ack_code,
   input logic       rsp_rcvd,
   input logic       bus_reset,
   input logic       retry_req,
   input logic       timeout,
   input logic       give_up,
   input logic       tx_enable
);
   AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({retry_req, timeout, give_up}));  // R6
   AST_BUSRST_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |=> !tx_enable);  // R3
   AST_BUSRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |=> !(retry_req || timeout || give_up));  // R3
   AST_RSP_BEATS_TMO: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_rcvd |=> !timeout);  // R9
   AST_TMO_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> $past(tick));  // R8
   AST_COMPLETE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_code == 2'd0) |=> !(retry_req || give_up));  // R5
   AST_RETRY_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      retry_req |-> $past(ack_valid && ack_code == 2'd2));  // R6
   AST_GIVEUP_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      give_up |-> $past(ack_valid && ack_code == 2'd2));  // R7
endmodule

bind split_txn_timer stt_checker u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .ack_valid(ack_valid),
   .ack_code(ack_code), .rsp_rcvd(rsp_rcvd), .bus_reset(bus_reset),
   .retry_req(retry_req), .timeout(timeout), .give_up(give_up),
   .tx_enable(tx_enable)
);

// File: tb/split_txn_timer_test.sv
module split_txn_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0, ctl_wr = 1'b0, tx_start = 1'b0;
   logic        ack_valid = 1'b0, rsp_rcvd = 1'b0, bus_reset = 1'b0;
   logic [1:0]  ack_code = 2'd0;
   logic [20:0] ctl_wdata = '0;
   logic        retry_req, timeout, give_up, tx_enable;

   int    n_cmp = 0, n_bad = 0, cyc_no = 0;
   bit    done = 1'b0;
   string tag = "R1";

   // behavioural reference
   int m_state = 0, m_ret = 0, m_el = 0;
   int m_frac = 800, m_sec = 0, m_max = 3, m_off = 0;
   bit e_retry = 0, e_tmo = 0, e_give = 0;

   always #2 clk = ~clk;

   split_txn_timer uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ctl_wr(ctl_wr),
      .ctl_wdata(ctl_wdata), .tx_start(tx_start), .ack_valid(ack_valid),
      .ack_code(ack_code), .rsp_rcvd(rsp_rcvd), .bus_reset(bus_reset),
      .retry_req(retry_req), .timeout(timeout), .give_up(give_up),
      .tx_enable(tx_enable)
   );

   function automatic logic [20:0] mk(int off, int mr, int s, int f);
      return 21'((off << 20) | (mr << 16) | (s << 13) | f);
   endfunction

   task automatic model_step();
      int of = m_frac, os = m_sec, om = m_max, oo = m_off;
      e_retry = 0; e_tmo = 0; e_give = 0;
      if (!rst_n) begin
         m_state = 0; m_ret = 0; m_el = 0;
         m_frac = 800; m_sec = 0; m_max = 3; m_off = 0;
         return;
      end
      if (ctl_wr) begin
         m_frac = int'(ctl_wdata[12:0]); m_sec = int'(ctl_wdata[15:13]);
         m_max = int'(ctl_wdata[19:16]); m_off = int'(ctl_wdata[20]);
      end
      if (bus_reset) begin
         m_off = 1; m_state = 0; m_ret = 0; m_el = 0;
         return;
      end
      case (m_state)
         0: if (tx_start && oo == 0) begin m_state = 1; m_ret = 0; end
         1: if (ack_valid) begin
               if (ack_code == 2'd0) m_state = 0;
               else if (ack_code == 2'd1) begin m_state = 2; m_el = 0; end
               else if (ack_code == 2'd2) begin
                  if (m_ret < om) begin m_ret++; e_retry = 1; end
                  else begin e_give = 1; m_state = 0; end
               end
            end
         default: if (rsp_rcvd) m_state = 0;
            else if (tick) begin
               int e = m_el + 1;
               if ((e / 8000 > os) || (e / 8000 == os && e % 8000 >= of)) begin
                  e_tmo = 1; m_state = 0;
               end else m_el = e;
            end
      endcase
   endtask

   task automatic cyc();
      @(posedge clk);
      model_step();
      @(negedge clk);
      cyc_no++;
      if (rst_n) begin
         n_cmp++;
         if ({retry_req, timeout, give_up, tx_enable} !==
             {e_retry, e_tmo, e_give, (m_off == 0)}) begin
            n_bad++;
            $display("FAIL %s cycle %0d: retry/tmo/give/en act=%b%b%b%b exp=%b%b%b%b",
                     tag, cyc_no, retry_req, timeout, give_up, tx_enable,
                     e_retry, e_tmo, e_give, (m_off == 0));
         end
      end
      tick = 0; ctl_wr = 0; tx_start = 0; ack_valid = 0;
      rsp_rcvd = 0; bus_reset = 0;
   endtask

   task automatic idle(int n, int tick_every);
      for (int i = 0; i < n; i++) begin
         tick = (tick_every != 0) && (i % tick_every == 0);
         cyc();
      end
   endtask

   task automatic ack(logic [1:0] c);
      ack_valid = 1; ack_code = c; cyc();
   endtask

   task automatic wr(logic [20:0] w);
      ctl_wr = 1; ctl_wdata = w; cyc();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      finish_run();
   end

   initial begin
      idle(3, 0);
      rst_n = 1;
      tag = "R1"; idle(3, 0);
      tag = "R5"; tx_start = 1; cyc(); ack(2'd0); idle(2, 0);
      tag = "R10"; ack(2'd2); idle(1, 0);
      tx_start = 1; cyc(); ack(2'd3); idle(1, 0);
      tag = "R6"; ack(2'd2); idle(1, 0); ack(2'd2); ack(2'd2); idle(1, 0);
      tag = "R7"; ack(2'd2); idle(2, 0); ack(2'd2); idle(1, 0);
      tag = "R2"; wr(mk(0, 0, 0, 5)); idle(1, 0);
      tag = "R7"; tx_start = 1; cyc(); ack(2'd2); idle(2, 0);
      tag = "R2"; wr(mk(0, 2, 0, 5));
      tag = "R8"; tx_start = 1; cyc(); ack(2'd1);
      tag = "R11"; tx_start = 1; cyc(); ack(2'd2); idle(3, 2);
      tag = "R8"; idle(12, 2);
      tag = "R9"; tx_start = 1; cyc(); ack(2'd1); idle(3, 1); rsp_rcvd = 1; cyc(); idle(8, 1);
      tx_start = 1; cyc(); ack(2'd1); idle(4, 1);
      rsp_rcvd = 1; tick = 1; cyc(); idle(8, 1);
      tag = "R8"; wr(mk(0, 2, 0, 8100));
      tx_start = 1; cyc(); ack(2'd1); idle(8010, 1);
      wr(mk(0, 2, 1, 3));
      tx_start = 1; cyc(); ack(2'd1); idle(8010, 1);
      wr(mk(0, 2, 0, 0));
      tx_start = 1; cyc(); ack(2'd1); idle(3, 1);
      tag = "R3"; wr(mk(0, 2, 0, 6));
      tx_start = 1; cyc(); ack(2'd1); idle(2, 1);
      bus_reset = 1; tick = 1; cyc(); idle(12, 1);
      tag = "R4"; tx_start = 1; cyc(); ack(2'd2); ack(2'd1); idle(10, 1);
      tag = "R3"; bus_reset = 1; ctl_wr = 1; ctl_wdata = mk(0, 2, 0, 6); cyc(); idle(2, 0);
      wr(mk(0, 2, 0, 6)); idle(2, 0);
      tag = "R4"; tx_start = 1; cyc(); ack(2'd2); ack(2'd0); idle(2, 0);
      tag = "R3"; tx_start = 1; cyc(); bus_reset = 1; cyc(); ack(2'd2); idle(2, 0);
      wr(mk(0, 2, 0, 6)); idle(2, 0);
      finish_run();
   end
endmodule